// File: doc/BRIEF.md
# Daisy-Chained Interrupt Acknowledge Chain

This block resolves interrupt priority by position in a chain. Each link keeps a local pending-request flag and a fixed vector value. Any link with a pending request pulls a shared active-low request line, so that line is the wired-OR of all the links. The CPU answers the request by raising an acknowledge into link 0.

The acknowledge then moves down the chain. A link with a request pending when the acknowledge reaches it claims the acknowledge. It drives its vector onto the shared vector bus, clears its pending flag and does not pass the acknowledge on. A link without a pending request forwards the acknowledge to the next link. Link 0 is nearest the CPU and has the highest priority.

Each link decides to claim or pass when the acknowledge first reaches it. That decision holds until the acknowledge drops, so a request that arrives during an acknowledge cannot break the chain. If no link claims, the bus is not driven and reads a default value, and the acknowledge comes out of the end of the chain.

Each link runs a three-state machine:
- IDLE: the link is waiting.
- IDLE to CLAIM: the acknowledge is high and a request is pending.
- IDLE to PASS: the acknowledge is high and no request is pending.
- PASS or CLAIM back to IDLE: the acknowledge has dropped.

Top module: `irq_daisy_chain`

## Requirements
- R1: A one-cycle pulse on `req_set[i]` sets link i's pending flag at the next rising edge. `irq_n` is low exactly while at least one link has a pending flag.
- R2: After reset no flag is pending and `irq_n` is 1. `vec_oe` is 0, `vec_bus` equals DEFAULT_VEC (0xFF) and `chain_ack_out` is 0.
- R3: When `cpu_ack` rises, the pending link with the lowest index claims it. That link drives `vec_bus` = VEC_BASE + index*VEC_STEP (0x20 + 4*index by default).
- R4: Link k has a latency of k+1 rising edges. After `cpu_ack` goes high, its claim appears on the outputs at the (k+1)-th rising edge, and the bus reads DEFAULT_VEC before then.
- R5: A claiming link does not forward the acknowledge. No link downstream of it sees the acknowledge, `chain_ack_out` stays 0, and at most one bit of `vec_oe` is set.
- R6: A link with no pending request forwards the acknowledge. Each such link adds one rising edge of delay.
- R7: The claiming link clears its own pending flag. Other pending flags stay set, and the next acknowledge is claimed by the next pending link in priority order.
- R8: The claim-or-pass decision is fixed while `cpu_ack` stays high. A request set on a link after it has chosen to pass does not give it the bus until a later acknowledge.
- R9: If no link claims, `vec_bus` reads DEFAULT_VEC and `vec_oe` is 0. `chain_ack_out` rises N rising edges after `cpu_ack` rises.
- R10: When `cpu_ack` falls, `vec_oe` clears and `vec_bus` returns to DEFAULT_VEC in the same cycle, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_set | input | N | Per-link request pulse; sets that link's pending flag |
| cpu_ack | input | 1 | Acknowledge from the CPU into link 0 |
| irq_n | output | 1 | Shared active-low request line (wired-OR of all links) |
| chain_ack_out | output | 1 | Acknowledge leaving the last link |
| vec_oe | output | N | Per-link vector output enables (a link drives only while it holds the acknowledge) |
| vec_bus | output | VW | Resolved vector bus; DEFAULT_VEC when no link drives |

## Verification
- A request pulse shows on `irq_n` one rising edge after it is applied.
- A claim by link k is due k+1 rising edges after `cpu_ack` rises. The bench checks `vec_bus`, `vec_oe` and `chain_ack_out` at every falling edge in that window. This confirms both the cycle in which the bus turns on and the cycles before it.
- The release is combinational, so it is checked one time step after `cpu_ack` falls.
- The bench sweeps every request pattern of a four-link chain. It computes the expected vector and the pattern left after the claim from the lowest set bit, then checks a second acknowledge against the leftover pattern.

// File: rtl/irq_chain_pkg.sv
package irq_chain_pkg;

    typedef enum logic [1:0] {
        LNK_IDLE  = 2'd0,
        LNK_PASS  = 2'd1,
        LNK_CLAIM = 2'd2
    } link_state_t;

endpackage

// File: rtl/irq_chain_link.sv
module irq_chain_link
    import irq_chain_pkg::*;
#(
    parameter int VW     = 8,
    parameter int MY_VEC = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_set,
    input  logic          ack_in,
    output logic          ack_out,
    output logic          vec_oe,
    output logic [VW-1:0] vec_data,
    output logic          pend_o
);

    localparam logic [VW-1:0] VEC_VAL = VW'(MY_VEC);

    link_state_t state_q, state_d;
    logic        pend_q;
    logic        claim_go;

    // Next-state selection: the decision is taken only on leaving IDLE.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LNK_IDLE: begin
                if (ack_in) state_d = pend_q ? LNK_CLAIM : LNK_PASS;
            end
            LNK_PASS: begin
                if (!ack_in) state_d = LNK_IDLE;
            end
            LNK_CLAIM: begin
                if (!ack_in) state_d = LNK_IDLE;
            end
            default: state_d = LNK_IDLE;
        endcase
    end

    assign claim_go = (state_q == LNK_IDLE) && ack_in && pend_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LNK_IDLE;
        else        state_q <= state_d;
    end

    // Pending flag: cleared by the claim, a coincident new request survives
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= (pend_q & ~claim_go) | req_set;
    end

    // Outputs
    always_comb begin
        ack_out  = (state_q == LNK_PASS) && ack_in;
        vec_oe   = (state_q == LNK_CLAIM) && ack_in;
        vec_data = vec_oe ? VEC_VAL : '0;
        pend_o   = pend_q;
    end

    // R5: a claiming link never forwards the acknowledge
    assert_swallow_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LNK_CLAIM) |-> !ack_out);

    // R3: a link only claims if it had a pending request
    assert_claim_needs_pend_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q == LNK_CLAIM) |-> $past(pend_q));

    // R7: the claim clears the pending flag
    assert_claim_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (claim_go && !req_set) |=> !pend_q);

    // R8: a passing link cannot turn into a claimer mid-acknowledge
    assert_frozen_pass_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LNK_PASS && ack_in) |=> (state_q != LNK_CLAIM));

endmodule

// File: rtl/irq_vec_merge.sv
module irq_vec_merge #(
    parameter int            N           = 4,
    parameter int            VW          = 8,
    parameter logic [VW-1:0] DEFAULT_VEC = '1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  oe,
    input  logic [VW-1:0] drv [N],
    output logic [VW-1:0] bus
);

    logic [VW-1:0] or_acc [N+1];

    assign or_acc[0] = '0;
    for (genvar i = 0; i < N; i++) begin : g_or
        assign or_acc[i+1] = or_acc[i] | (oe[i] ? drv[i] : '0);
    end

    // Undriven bus reads the pull value
    assign bus = (|oe) ? or_acc[N] : DEFAULT_VEC;

    // R5: never more than one driver on the shared bus
    assert_single_driver_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(oe));

endmodule

// File: rtl/irq_daisy_chain.sv
module irq_daisy_chain #(
    parameter int            N           = 4,
    parameter int            VW          = 8,
    parameter int            VEC_BASE    = 32,
    parameter int            VEC_STEP    = 4,
    parameter logic [VW-1:0] DEFAULT_VEC = 8'hFF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req_set,
    input  logic          cpu_ack,
    output logic          irq_n,
    output logic          chain_ack_out,
    output logic [N-1:0]  vec_oe,
    output logic [VW-1:0] vec_bus
);

    logic [N:0]    ack_link;
    logic [N-1:0]  pend;
    logic [VW-1:0] drv [N];

    assign ack_link[0] = cpu_ack;

    for (genvar i = 0; i < N; i++) begin : g_link
        localparam int LINK_VEC = VEC_BASE + i * VEC_STEP;
        irq_chain_link #(
            .VW     (VW),
            .MY_VEC (LINK_VEC)
        ) u_link (
            .clk      (clk),
            .rst_n    (rst_n),
            .req_set  (req_set[i]),
            .ack_in   (ack_link[i]),
            .ack_out  (ack_link[i+1]),
            .vec_oe   (vec_oe[i]),
            .vec_data (drv[i]),
            .pend_o   (pend[i])
        );
    end

    // Wired-OR of active-low request contributions
    assign irq_n         = ~(|pend);
    assign chain_ack_out = ack_link[N];

    irq_vec_merge #(
        .N           (N),
        .VW          (VW),
        .DEFAULT_VEC (DEFAULT_VEC)
    ) u_merge (
        .clk   (clk),
        .rst_n (rst_n),
        .oe    (vec_oe),
        .drv   (drv),
        .bus   (vec_bus)
    );

    // R9/R5: an acknowledge leaving the chain means nobody drives the bus
    assert_unclaimed_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        chain_ack_out |-> (vec_oe == '0));

    // R10: no driver without the CPU acknowledge
    assert_oe_needs_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_ack |-> (vec_oe == '0));

endmodule

// File: tb/irq_daisy_chain_bench.sv
module irq_daisy_chain_bench;

    localparam int N     = 4;
    localparam int VW    = 8;
    localparam int BASE  = 32;
    localparam int STEP  = 4;
    localparam int DEFV  = 255;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  req_set = '0;
    logic          cpu_ack = 1'b0;
    logic          irq_n;
    logic          chain_ack_out;
    logic [N-1:0]  vec_oe;
    logic [VW-1:0] vec_bus;

    int n_cmp = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    irq_daisy_chain #(
        .N(N), .VW(VW), .VEC_BASE(BASE), .VEC_STEP(STEP), .DEFAULT_VEC(8'hFF)
    ) u_irq_daisy_chain (
        .clk(clk), .rst_n(rst_n), .req_set(req_set), .cpu_ack(cpu_ack),
        .irq_n(irq_n), .chain_ack_out(chain_ack_out), .vec_oe(vec_oe), .vec_bus(vec_bus)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int lowest(input int p);
        for (int i = 0; i < N; i++) if (p[i]) return i;
        return N;
    endfunction

    function automatic int vec_of(input int k);
        return (k < N) ? ((BASE + k * STEP) & 255) : DEFV;
    endfunction

    task automatic do_reset();
        rst_n = 1'b0;
        cpu_ack = 1'b0;
        req_set = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // Raises the acknowledge and checks every cycle of the claim window
    task automatic ack_window(input int p, input string tag);
        int k;
        k = lowest(p);
        cpu_ack = 1'b1;
        for (int c = 1; c <= N + 1; c++) begin
            bit drv;
            @(negedge clk);
            drv = (p != 0) && (c >= k + 1);
            chk({tag, " R3 R4 vec_bus"}, int'(vec_bus), drv ? vec_of(k) : DEFV);
            chk({tag, " R5 vec_oe"}, int'(vec_oe), drv ? (1 << k) : 0);
            chk({tag, " R6 R9 chain_ack_out"}, int'(chain_ack_out),
                ((p == 0) && (c >= N)) ? 1 : 0);
        end
        cpu_ack = 1'b0;
        #1;
        chk({tag, " R10 bus release"}, int'(vec_bus), DEFV);
        chk({tag, " R10 oe release"}, int'(vec_oe), 0);
        @(negedge clk);
    endtask

    initial begin : watchdog
        #200000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : main
        for (int p = 0; p < (1 << N); p++) begin
            int k, rem;
            do_reset();
            chk("R2 irq_n", int'(irq_n), 1);
            chk("R2 vec_bus", int'(vec_bus), DEFV);
            chk("R2 vec_oe", int'(vec_oe), 0);
            chk("R2 chain_ack_out", int'(chain_ack_out), 0);
            req_set = N'(p);
            @(negedge clk);
            req_set = '0;
            chk("R1 irq_n after set", int'(irq_n), (p == 0) ? 1 : 0);
            ack_window(p, "first");
            k = lowest(p);
            rem = (k < N) ? (p & ~(1 << k)) : 0;
            chk("R7 irq_n after claim", int'(irq_n), (rem == 0) ? 1 : 0);
            if (rem != 0) ack_window(rem, "second R7");
        end

        // R8: request arriving after link 0 chose to pass
        do_reset();
        cpu_ack = 1'b1;
        repeat (N + 1) @(negedge clk);
        req_set = 4'b0001;
        @(negedge clk);
        req_set = '0;
        @(negedge clk);
        chk("R8 bus stays default", int'(vec_bus), DEFV);
        chk("R8 chain ack still forwarded", int'(chain_ack_out), 1);
        chk("R8 irq_n shows new request", int'(irq_n), 0);
        cpu_ack = 1'b0;
        @(negedge clk);
        ack_window(1, "R8 next ack");
        chk("R8 irq_n cleared", int'(irq_n), 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule